// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A single-port synchronous memory whose command and data phases are offset by a fixed two-cycle pipeline. Address and control are captured on a rising clock edge. The data belonging to that command, whether it is read or written, sits on the data pins in the clock cycle that ends two recognized edges later. Because writes and reads use the same delay, commands of either type can follow each other on every cycle, and the shared data bus never needs an idle slot when the direction changes. The bidirectional bus is modelled as separate `din`, `dout` and `dout_en` signals.

A single load/advance input either opens a new access at the supplied address or steps an internal 2-bit counter over the low address bits. This yields four-beat bursts in linear or interleaved order, and the bursts wrap. The block also has a clock-enable stall, three chip-select inputs, per-lane write strobes in which each lane carries a parity bit, and a pipelined deselect. Memory depth is a parameter.

Top module: `zt_pipe_sram`

## Requirements
- R1: A read command (`cke_n`=0, all three selects active, `adv`=0, `wr_n`=1) sampled at recognized edge k makes `dout` carry the addressed word, with `dout_en`=1 while `oe_n`=0, in the cycle between recognized edges k+1 and k+2.
- R2: For a write command sampled at recognized edge k, the data on `din` is stored at recognized edge k+2. A read issued one cycle behind a write to the same address returns the newly written lanes.
- R3: While `cke_n`=1, every synchronous input is ignored and all pipeline, burst and output state holds, including `dout` and `dout_en`.
- R4: Lane i is `din[i*LANE_W +: LANE_W]`, and its top bit is that lane's parity bit. `lane_wr_n[i]`=0, sampled with the command or burst beat, writes lane i. Lanes whose strobe is 1 keep their old contents.
- R5: With `order_ilv`=0, burst beats take low address bits start, start+1, start+2, start+3 (modulo 4). The burst keeps wrapping while `adv` stays 1.
- R6: With `order_ilv`=1, the beat low bits are start XOR 0,1,2,3. During a burst with `adv`=1, the selects and `wr_n` are ignored, and the read/write type set at the start is kept.
- R7: `adv`=0 with any select inactive starts nothing and ends any burst. A later `adv`=1 then issues no access. Accesses already in the pipeline complete, and `dout_en` is 0 two edges after the deselect.
- R8: `dout_en` is 0 during the data phase of a write, whenever `oe_n`=1 (which acts at once, without a clock), and in any cycle without read data.
- R9: A synchronous active-high `rst` empties the pipeline and ends any burst, so `dout_en` is 0 after the reset edge. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low; 1 stalls the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 loads a new command, 1 advances the burst |
| wr_n | input | 1 | 0 write, 1 read, sampled at load |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data bus |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| dout | output | LANES*LANE_W | Read data register |
| dout_en | output | 1 | Bus drive enable |

## Verification
A wrong pipeline valid or type bit appears at the ports two recognized edges after the command: `dout_en` rises on a write slot, or stays low on a read slot. A wrong burst counter or order shows up on the very next beat, because the read word comes from the wrong address. A missing forward from a write to a read right behind it shows up as stale lanes in the read word. A broken stall shows up in the stalled cycle itself, as a change on `dout`, or one cycle early, as a shifted read sequence.

// File: rtl/zt_pipe_sram.sv
module zt_pipe_sram #(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cke_n,
  input  logic                     sel_a_n,
  input  logic                     sel_b,
  input  logic                     sel_c_n,
  input  logic                     adv,
  input  logic                     wr_n,
  input  logic [LANES-1:0]         lane_wr_n,
  input  logic                     order_ilv,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  din,
  input  logic                     oe_n,
  output logic [LANES*LANE_W-1:0]  dout,
  output logic                     dout_en
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  wire go      = !cke_n;
  wire chip_on = !sel_a_n && sel_b && !sel_c_n;
  wire start   = !adv && chip_on;

  logic              bst_act, bst_wr;
  logic [1:0]        bst_cnt, bst_lo0;
  logic [ADDR_W-1:2] bst_hi;

  wire [1:0] nxt_cnt = bst_cnt + 2'd1;
  wire [1:0] step_lo = order_ilv ? (bst_lo0 ^ nxt_cnt) : (bst_lo0 + nxt_cnt);
  wire       step    = adv && bst_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      bst_act <= 1'b0;
    end else if (go) begin
      if (!adv) begin
        bst_act <= chip_on;
        bst_cnt <= 2'd0;
        bst_lo0 <= addr[1:0];
        bst_hi  <= addr[ADDR_W-1:2];
        bst_wr  <= !wr_n;
      end else if (bst_act) begin
        bst_cnt <= nxt_cnt;
      end
    end
  end

  logic              s1_v, s1_wr, s2_v, s2_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_be, s2_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else if (go) begin
      s1_v    <= start || step;
      s1_wr   <= start ? !wr_n : bst_wr;
      s1_addr <= start ? addr : {bst_hi, step_lo};
      s1_be   <= ~lane_wr_n;
      s2_v    <= s1_v;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  wire commit = go && s2_v && s2_wr;
  wire fwd_hit = s2_v && s2_wr && (s2_addr == s1_addr);
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = mem[s1_addr];
    for (int i = 0; i < LANES; i++)
      if (fwd_hit && s2_be[i]) rd_word[i*LANE_W +: LANE_W] = din[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (commit)
      for (int i = 0; i < LANES; i++)
        if (s2_be[i]) mem[s2_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
  end

  logic [DATA_W-1:0] rd_q;
  always_ff @(posedge clk)
    if (go && s1_v && !s1_wr) rd_q <= rd_word;

  assign dout    = rd_q;
  assign dout_en = s2_v && !s2_wr && !oe_n;

  assert_read_drive_R1: assert property (@(posedge clk) disable iff (rst)
    (go && start && wr_n) ##1 go |=> (dout_en || oe_n));

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    cke_n |=> $stable(dout));

  assert_desel_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (go && !adv && !chip_on) ##1 go |=> !dout_en);

  assert_write_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (go && start && !wr_n) ##1 go |=> !dout_en);

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dout_en);
endmodule

// File: tb/zt_pipe_sram_tb.sv
module zt_pipe_sram_tb;
  localparam int PER = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic cke_n, sel_a_n, sel_b, sel_c_n, adv, wr_n, order_ilv, oe_n;
  logic [1:0] lane_wr_n;
  logic [4:0] addr;
  logic [17:0] din, dout;
  logic dout_en;

  always #(PER/2) clk = ~clk;

  zt_pipe_sram u_dut (
    .clk(clk), .rst(rst), .cke_n(cke_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .adv(adv), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .order_ilv(order_ilv), .addr(addr), .din(din), .oe_n(oe_n),
    .dout(dout), .dout_en(dout_en)
  );

  int n_chk = 0, n_fail = 0, desel_k = 0;
  bit done = 0;

  typedef struct packed {
    logic hold; logic sel; logic adv; logic wrn; logic [1:0] strb;
    logic [4:0] a; logic [17:0] d; logic een; logic chk; logic [17:0] e;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,2'b00,5'd3,18'h00000,1'b0,1'b0,18'h00000},
    '{1'b0,1'b1,1'b0,1'b0,2'b00,5'd4,18'h00000,1'b0,1'b0,18'h00000},
    '{1'b0,1'b1,1'b0,1'b1,2'b11,5'd3,18'h12345,1'b0,1'b0,18'h00000},
    '{1'b0,1'b1,1'b0,1'b1,2'b11,5'd4,18'h2ABCD,1'b0,1'b0,18'h00000},
    '{1'b0,1'b1,1'b0,1'b0,2'b10,5'd3,18'h00000,1'b1,1'b1,18'h12345},
    '{1'b0,1'b0,1'b0,1'b1,2'b11,5'd0,18'h00000,1'b1,1'b1,18'h2ABCD},
    '{1'b0,1'b1,1'b0,1'b1,2'b11,5'd3,18'h3FF00,1'b0,1'b0,18'h00000},
    '{1'b1,1'b1,1'b0,1'b0,2'b00,5'd4,18'h3FFFF,1'b0,1'b0,18'h00000},
    '{1'b0,1'b1,1'b0,1'b1,2'b11,5'd4,18'h00000,1'b0,1'b0,18'h00000},
    '{1'b0,1'b0,1'b0,1'b1,2'b11,5'd0,18'h00000,1'b1,1'b1,18'h12300},
    '{1'b0,1'b0,1'b0,1'b1,2'b11,5'd0,18'h00000,1'b1,1'b1,18'h2ABCD},
    '{1'b0,1'b0,1'b0,1'b1,2'b11,5'd0,18'h00000,1'b0,1'b0,18'h00000}
  };

  task automatic drv(input logic h, input logic s, input logic a, input logic w,
                     input logic [1:0] b, input logic [4:0] ad, input logic [17:0] d);
    cke_n = h; adv = a; wr_n = w; lane_wr_n = b; addr = ad; din = d;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    if (!s) begin
      case (desel_k % 3)
        0: sel_a_n = 1'b1;
        1: sel_b   = 1'b0;
        default: sel_c_n = 1'b1;
      endcase
      desel_k++;
    end
    @(negedge clk);
  endtask

  task automatic chk(input logic ee, input logic cv, input logic [17:0] ev, input string tag);
    n_chk++;
    if (dout_en !== ee || (cv && dout !== ev)) begin
      n_fail++;
      $display("FAIL %s: dout_en=%b dout=%h, expected dout_en=%b dout=%h", tag, dout_en, dout, ee, ev);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(PER * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  localparam logic [17:0] D6 = 18'h06006, D7 = 18'h07007, D4 = 18'h3C0C4, D5 = 18'h05005;
  localparam logic [17:0] E4 = (18'h2ABCD & 18'h3FE00) | (D4 & 18'h001FF);

  initial begin
    oe_n = 1'b0; order_ilv = 1'b1;
    cke_n = 1'b0; adv = 1'b0; wr_n = 1'b1; lane_wr_n = 2'b11; addr = '0; din = '0;
    sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(1'b0, 1'b0, 18'h0, "R9 reset state");

    // R1 R2 R3 R4 R7 R8: interleaved write/read/deselect/stall vectors
    for (int i = 0; i < NV; i++) begin
      chk(TBL[i].een, TBL[i].chk, TBL[i].e, $sformatf("R1/R2/R3/R4/R7/R8 vector %0d", i));
      drv(TBL[i].hold, TBL[i].sel, TBL[i].adv, TBL[i].wrn, TBL[i].strb, TBL[i].a, TBL[i].d);
    end

    // R5 linear burst write from 6, R6 selects and wr_n ignored on beats
    order_ilv = 1'b0;
    drv(0, 1, 0, 0, 2'b00, 5'd6, 18'h0);
    drv(0, 0, 1, 1, 2'b00, 5'd0, 18'h0);
    drv(0, 0, 1, 1, 2'b10, 5'd0, D6);
    drv(0, 1, 1, 1, 2'b00, 5'd0, D7);
    order_ilv = 1'b1;
    drv(0, 1, 0, 1, 2'b11, 5'd5, D4);
    drv(0, 1, 1, 0, 2'b11, 5'd0, D5);
    chk(1'b1, 1'b1, D5, "R2 R6 forwarded read beat 0 addr 5");
    drv(0, 1, 1, 1, 2'b11, 5'd0, 18'h0);
    chk(1'b1, 1'b1, E4, "R4 R6 beat 1 addr 4 lane0 only");
    drv(0, 1, 1, 1, 2'b11, 5'd0, 18'h0);
    chk(1'b1, 1'b1, D7, "R5 R6 beat 2 addr 7");
    drv(0, 1, 1, 1, 2'b11, 5'd0, 18'h0);
    chk(1'b1, 1'b1, D6, "R5 R6 beat 3 addr 6");
    drv(0, 0, 0, 1, 2'b11, 5'd0, 18'h0);
    chk(1'b1, 1'b1, D5, "R5 R6 wrap beat addr 5");
    drv(0, 1, 1, 1, 2'b11, 5'd0, 18'h0);
    chk(1'b0, 1'b0, 18'h0, "R7 bus off after deselect");
    drv(0, 0, 0, 1, 2'b11, 5'd0, 18'h0);
    chk(1'b0, 1'b0, 18'h0, "R7 advance after deselect issues nothing");

    // R3 stall holds read data, R8 output enable
    drv(0, 1, 0, 1, 2'b11, 5'd6, 18'h0);
    drv(0, 0, 0, 1, 2'b11, 5'd0, 18'h0);
    chk(1'b1, 1'b1, D6, "R1 read addr 6");
    drv(1, 1, 0, 1, 2'b11, 5'd7, 18'h0);
    chk(1'b1, 1'b1, D6, "R3 stalled output held");
    oe_n = 1'b1; #1;
    chk(1'b0, 1'b0, 18'h0, "R8 oe_n high disables drive");
    oe_n = 1'b0;
    drv(0, 0, 0, 1, 2'b11, 5'd0, 18'h0);
    chk(1'b0, 1'b0, 18'h0, "R3 R7 bubble after stall");

    // R9 reset empties pipeline
    drv(0, 1, 0, 1, 2'b11, 5'd6, 18'h0);
    rst = 1'b1;
    drv(0, 0, 0, 1, 2'b11, 5'd0, 18'h0);
    chk(1'b0, 1'b0, 18'h0, "R9 reset drops pending read");
    rst = 1'b0;
    drv(0, 1, 0, 1, 2'b11, 5'd6, 18'h0);
    drv(0, 0, 0, 1, 2'b11, 5'd0, 18'h0);
    chk(1'b1, 1'b1, D6, "R9 memory kept over reset");

    finish_run();
  end
endmodule